// File: doc/BRIEF.md
# Bit-Plane Sample Stream Serializer

This block turns a stream of 4-bit quantized I/Q samples into a serial bit stream organised by bit plane. Each sample carries four bit lines: lines 0 and 1 belong to the I channel and lines 2 and 3 to the Q channel. In sign/magnitude format, line 0 is the I sign, line 1 the I magnitude, line 2 the Q sign and line 3 the Q magnitude. The block collects 16 consecutive samples into a slice, transposes the slice into one 16-bit word per bit line, and sends a mode-selected subset of those words out as back-to-back 16-bit segments. It does this while the next slice is being collected.

The block runs on the serial clock. The sample rate arrives as a one-cycle strobe. After the selected planes of a slice have been sent, the output carries zeros until the next slice is ready. A segment-sync pulse marks the first bit of every valid segment. A separate time-sync pulse repeats every 128·2^k sample strobes, where k is a 3-bit field. Clearing the stream enable silences every output and restarts the capture from an empty slice.

Top module: `bitplane_serializer`

## Requirements
- R1: Bit k of each captured sample (k = 0..3) is carried only in plane k. Plane 0 is I sign, plane 1 is I magnitude, plane 2 is Q sign and plane 3 is Q magnitude.
- R2: A slice closes on the 16th accepted sample strobe after enable or after the previous slice. The first bit of the slice's first segment appears on `ser_out` in the clock cycle right after that strobe's clock edge.
- R3: Within a segment, bits are sent oldest sample first, one bit per serial clock, for 16 consecutive cycles.
- R4: `plane_mode` selects the planes and their order: 0 sends plane 0 only; 1 sends plane 0 then plane 1; 2 sends plane 0 then plane 2; 3 sends planes 0, 1, 2 and 3 in that order. The segments follow each other with no gap. The mode is taken when a slice closes.
- R5: After the last selected segment of a slice, `ser_out` stays 0 until the next slice starts.
- R6: `seg_sync` is high for exactly one cycle, together with the first bit of each valid segment, and is never high during zero padding.
- R7: `time_sync` is a one-cycle pulse. It is high in the cycle after the clock edge of every (128 << `ts_sel`)-th sample strobe counted from enable.
- R8: While `strm_en` is low, `ser_out`, `seg_sync` and `time_sync` are 0 from the next cycle on, and all counters clear. On re-enable, capture starts a fresh slice and the time-sync count starts from zero.
- R9: After reset, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strm_en | input | 1 | Stream enable; low clears and silences the block |
| smp_tick | input | 1 | One-cycle strobe marking a new sample |
| smp_data | input | 4 | Sample bit lines: [0] I sign, [1] I mag, [2] Q sign, [3] Q mag |
| plane_mode | input | 2 | Plane selection, encoded as in R4 |
| ts_sel | input | 3 | Time-sync period exponent, period = 128 << ts_sel strobes |
| ser_out | output | 1 | Serial plane data |
| seg_sync | output | 1 | First-bit marker of each valid segment |
| time_sync | output | 1 | Periodic time-sync pulse |

## Verification
Every plane mode is run over several slices with a strobe every fourth clock. This is the tightest legal rate for four-plane mode, so the last bit of one slice sits right against the first bit of the next. A design that sent the newest sample first, substituted plane 1 for plane 2 in mode 2, or left a gap between segments would mismatch the computed bit stream in specific cycles. Zero padding is checked in two-plane and one-plane modes, where a design that kept shifting stale data or raised segment sync during the pad would be caught. The stream is dropped mid-slice and restarted each run: a design that kept its sample or time-sync count across the disable would misalign every following slice and pulse. The time-sync pulse is checked at periods of 128, 256 and 512 strobes, which exposes an off-by-one in the period or a pulse that lasts more than one cycle.

// File: rtl/bps_pkg.sv
// Package: shared constants and plane-ordering helpers for the bit-plane
// serializer. Assumes exactly four bit lines per sample (two I, two Q).
package bps_pkg;

    localparam int LANES = 4;
    localparam int PLW   = 2;   // width of a plane index

    typedef enum logic [1:0] {
        MODE_P0    = 2'd0,
        MODE_P01   = 2'd1,
        MODE_P02   = 2'd2,
        MODE_P0123 = 2'd3
    } plane_mode_e;

    // Number of planes sent per slice for a given mode.
    function automatic logic [PLW:0] planes_in_mode(input plane_mode_e m);
        case (m)
            MODE_P0:    return 3'd1;
            MODE_P01:   return 3'd2;
            MODE_P02:   return 3'd2;
            default:    return 3'd4;
        endcase
    endfunction

    // Plane number sent in position idx of the slice for a given mode.
    function automatic logic [PLW-1:0] plane_at(input plane_mode_e m, input logic [PLW-1:0] idx);
        if (m == MODE_P02 && idx == 2'd1) return 2'd2;
        return idx;
    endfunction

endpackage

// File: rtl/bps_capture.sv
// Module: bps_capture
// Collects one bit per lane on every sample strobe into per-lane holding
// registers. On the strobe that completes a slice, it presents the full slice
// (including the bit arriving on that strobe) together with a one-cycle
// slice_done. The oldest sample ends up at the MSB of each lane word.
// Assumes: strobe is a single-cycle pulse; en low clears the fill count.
module bps_capture
    import bps_pkg::*;
#(
    parameter int SLICE_LEN = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  en,
    input  logic                                  tick,
    input  logic [LANES-1:0]                      data,
    output logic                                  slice_done,
    output logic [LANES-1:0][SLICE_LEN-1:0]       slice_bits
);

    localparam int CNTW = $clog2(SLICE_LEN);
    localparam logic [CNTW-1:0] LAST = CNTW'(SLICE_LEN - 1);

    logic [LANES-1:0][SLICE_LEN-1:0] hold;
    logic [CNTW-1:0]                 fill;

    // Full slice view: stored bits followed by the bit arriving now.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign slice_bits[k] = {hold[k][SLICE_LEN-2:0], data[k]};
    end

    assign slice_done = en && tick && (fill == LAST);

    // Shift a new bit into every lane and track how full the slice is.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hold <= '0;
            fill <= '0;
        end else if (tick) begin
            for (int k = 0; k < LANES; k++) begin
                hold[k] <= slice_bits[k];
            end
            fill <= (fill == LAST) ? '0 : fill + 1'b1;
        end
    end

    AST_FILL_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        slice_done |=> (fill == '0));                                   // R2

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (fill == '0));                                          // R8

endmodule

// File: rtl/bps_plane_shifter.sv
// Module: bps_plane_shifter
// Takes a completed slice into its shift registers and sends the planes
// chosen by the mode latched at load time. Each plane goes out as a
// contiguous segment, MSB (oldest sample) first, and the output is padded
// with zeros once the selected planes are done. A new load always restarts
// the sequence.
// Assumes: the serial clock is fast enough that a slice is fully sent
// before the next load (2x the sample rate for two planes, 4x for four).
module bps_plane_shifter
    import bps_pkg::*;
#(
    parameter int SLICE_LEN = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  en,
    input  logic                                  load,
    input  logic [LANES-1:0][SLICE_LEN-1:0]       slice_in,
    input  logic [1:0]                            mode,
    output logic                                  ser_out,
    output logic                                  seg_sync
);

    localparam int BCW = $clog2(SLICE_LEN);
    localparam logic [BCW-1:0] BLAST = BCW'(SLICE_LEN - 1);

    logic [LANES-1:0][SLICE_LEN-1:0] sreg;
    plane_mode_e                     mode_q;
    logic [PLW-1:0]                  pos;
    logic [BCW-1:0]                  bcnt;
    logic                            busy;
    logic [PLW-1:0]                  cur;
    logic [PLW:0]                    nplanes;

    assign cur      = plane_at(mode_q, pos);
    assign nplanes  = planes_in_mode(mode_q);
    assign ser_out  = busy && sreg[cur][SLICE_LEN-1];
    assign seg_sync = busy && (bcnt == '0);

    // Load a slice, then walk through its bits and the selected planes.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sreg   <= '0;
            mode_q <= MODE_P0;
            pos    <= '0;
            bcnt   <= '0;
            busy   <= 1'b0;
        end else if (load) begin
            sreg   <= slice_in;
            mode_q <= plane_mode_e'(mode);
            pos    <= '0;
            bcnt   <= '0;
            busy   <= 1'b1;
        end else if (busy) begin
            sreg[cur] <= {sreg[cur][SLICE_LEN-2:0], 1'b0};
            bcnt      <= bcnt + 1'b1;
            if (bcnt == BLAST) begin
                if ({1'b0, pos} == nplanes - 1'b1) begin
                    busy <= 1'b0;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end

    AST_LOAD_STARTS_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load) |=> seg_sync);                                     // R2

    AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_sync && !load) |=> !seg_sync);                             // R6

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!ser_out && !seg_sync));                               // R8

endmodule

// File: rtl/bps_time_sync.sv
// Module: bps_time_sync
// Counts sample strobes and emits a one-cycle pulse, in the cycle after the
// strobe that completes each period of BASE << sel strobes.
// Assumes: sel is held steady while streaming; en low restarts the count.
module bps_time_sync #(
    parameter int BASE  = 128,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse
);

    localparam int CW = $clog2(BASE) + (1 << SEL_W) - 1;

    logic [CW-1:0] tcnt;
    logic [CW-1:0] last_cnt;

    assign last_cnt = CW'((BASE << sel) - 1);

    // Advance the strobe count and fire at the end of every period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            tcnt  <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (tick) begin
                if (tcnt >= last_cnt) begin
                    tcnt  <= '0;
                    pulse <= 1'b1;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end

    AST_TS_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(tick));                                         // R7

    AST_TS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);                                              // R7

endmodule

// File: rtl/bitplane_serializer.sv
// Module: bitplane_serializer (top)
// Captures 4-bit I/Q samples into 16-sample slices, transposes them into
// bit planes and streams a mode-selected subset of planes serially, with a
// segment-start marker and a periodic time-sync pulse.
// Assumes: single clock (the serial clock); samples arrive as one-cycle
// strobes at a rate that leaves room for the selected planes.
module bitplane_serializer
    import bps_pkg::*;
#(
    parameter int SLICE_LEN = 16,
    parameter int TS_BASE   = 128,
    parameter int TS_SEL_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strm_en,
    input  logic                smp_tick,
    input  logic [LANES-1:0]    smp_data,
    input  logic [1:0]          plane_mode,
    input  logic [TS_SEL_W-1:0] ts_sel,
    output logic                ser_out,
    output logic                seg_sync,
    output logic                time_sync
);

    logic                            slice_done;
    logic [LANES-1:0][SLICE_LEN-1:0] slice_bits;

    bps_capture #(.SLICE_LEN(SLICE_LEN)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (strm_en),
        .tick       (smp_tick),
        .data       (smp_data),
        .slice_done (slice_done),
        .slice_bits (slice_bits)
    );

    bps_plane_shifter #(.SLICE_LEN(SLICE_LEN)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (strm_en),
        .load     (slice_done),
        .slice_in (slice_bits),
        .mode     (plane_mode),
        .ser_out  (ser_out),
        .seg_sync (seg_sync)
    );

    bps_time_sync #(.BASE(TS_BASE), .SEL_W(TS_SEL_W)) u_tsync (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (strm_en),
        .tick  (smp_tick),
        .sel   (ts_sel),
        .pulse (time_sync)
    );

    AST_SYNC_MARKS_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        seg_sync |-> strm_en || $past(strm_en));                        // R6

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!ser_out && !seg_sync && !time_sync));              // R9

endmodule

// File: tb/bitplane_serializer_tb.sv
// Bench: runs every plane mode with a sample strobe every 4th clock and
// compares all outputs each cycle against a stream computed arithmetically.
module bitplane_serializer_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       strm_en;
    logic       smp_tick;
    logic [3:0] smp_data;
    logic [1:0] plane_mode;
    logic [2:0] ts_sel;
    logic       ser_out;
    logic       seg_sync;
    logic       time_sync;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bitplane_serializer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .strm_en    (strm_en),
        .smp_tick   (smp_tick),
        .smp_data   (smp_data),
        .plane_mode (plane_mode),
        .ts_sel     (ts_sel),
        .ser_out    (ser_out),
        .seg_sync   (seg_sync),
        .time_sync  (time_sync)
    );

    function automatic logic [3:0] sample_val(input int n, input int seed);
        return 4'((n * 7 + (n / 8) * 5 + seed) % 16);
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    // State after clock edge x of a run (strobe on every edge with x%4==0).
    task automatic check_state(input int x, input int mode, input int tsel, input int seed);
        int  np;
        int  per;
        int  t;
        int  j;
        int  p;
        int  b;
        int  pl;
        logic es;
        logic ey;
        logic et;
        np  = (mode == 0) ? 1 : (mode == 3) ? 4 : 2;
        per = 128 << tsel;
        es  = 1'b0;
        ey  = 1'b0;
        if (x >= 60) begin
            t = (x - 60) % 64;
            j = (x - 60) / 64;
            if (t < 16 * np) begin
                p  = t / 16;
                b  = t % 16;
                pl = (mode == 2 && p == 1) ? 2 : p;
                // R1 plane k carries sample bit k; R3 oldest first; R4 order
                es = sample_val(16 * j + b, seed)[pl];
                ey = (b == 0);
            end
        end
        et = (x % 4 == 0) && (((x / 4) + 1) % per == 0);
        if (x < 60)            chk("R2 ser_out before first slice", ser_out, es);
        else if (t >= 16 * np) chk("R5 ser_out zero padding", ser_out, es);
        else if (t < 16)       chk("R3 ser_out first segment", ser_out, es);
        else                   chk("R4 ser_out later segment", ser_out, es);
        chk("R6 seg_sync", seg_sync, ey);
        chk("R7 time_sync", time_sync, et);
    endtask

    // One enabled run of nedges clock edges, ended by dropping the enable.
    task automatic run(input int mode, input int tsel, input int seed, input int nedges);
        for (int e = 0; e <= nedges; e++) begin
            @(negedge clk);
            if (e > 0) check_state(e - 1, mode, tsel, seed);
            if (e < nedges) begin
                strm_en    = 1'b1;
                smp_tick   = (e % 4 == 0);
                smp_data   = sample_val(e / 4, seed);
                plane_mode = 2'(mode);
                ts_sel     = 3'(tsel);
            end else begin
                strm_en  = 1'b0;
                smp_tick = 1'b0;
            end
        end
        @(negedge clk);
        // R8 outputs quiet the cycle after the enable drops
        chk("R8 ser_out off", ser_out, 1'b0);
        chk("R8 seg_sync off", seg_sync, 1'b0);
        chk("R8 time_sync off", time_sync, 1'b0);
    endtask

    initial begin
        rst_n      = 1'b0;
        strm_en    = 1'b0;
        smp_tick   = 1'b0;
        smp_data   = 4'h0;
        plane_mode = 2'd0;
        ts_sel     = 3'd0;
        repeat (3) @(negedge clk);
        chk("R9 ser_out reset", ser_out, 1'b0);
        chk("R9 seg_sync reset", seg_sync, 1'b0);
        chk("R9 time_sync reset", time_sync, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // Runs stop mid-slice, so each following run also checks a fresh
        // restart after disable (R8).
        run(0, 0, 3, 1100);
        run(1, 0, 11, 1100);
        run(2, 1, 5, 1100);
        run(3, 2, 9, 2200);
        run(3, 0, 14, 700);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule